// File: doc/BRIEF.md
# I2C Controller Start and Address Sequencer

This block is the controller-side front end of an I2C port. Software or a neighbouring engine loads a transfer description (7-bit or 10-bit addressing, a 10-bit target address, the direction, a header-only option for 10-bit reads and a requested length) and then raises a start request. The block waits until the bus is idle. It holds off for a programmable bus-free delay, issues a START condition and shifts the address byte or bytes out MSB first on open-drain SCL/SDA. It then samples the acknowledge bit and reports the outcome.

The SCL low-phase count also sets the bus-free delay and the setup time before a repeated START. The SCL high-phase count also sets the START hold time and the setup time before a STOP. When the target acknowledges the last address byte, the block keeps SCL low and hands the bus to the data stage that follows it. A NACK ends the attempt with a STOP. Losing arbitration releases both lines and leaves the block in target mode.

All pins are plain control and status signals. The open-drain pins use output-enable outputs: a 1 on `scl_oe` or `sda_oe` pulls the line low.

Top module: `i2c_start_seq`

## Requirements
- R1: A configuration write latches a byte count of `cfg_len` when it is below 255, and 0xFF (255) when it is 255 or more.
- R2: A configuration write made while `start_pending` is 1 has no effect. The latched count and the address sent on the bus stay as they were.
- R3: After a start request, a START (SDA pulled low while SCL is high) is driven only after `bus_busy` has been 0 for `tim_low`+1 consecutive cycles. `sda_oe` rises on the seventh clock edge after a STOP is put on the bus, counting the edge that samples the STOP.
- R4: In 7-bit mode one byte is sent, {addr[6:0], rw}, MSB first, where rw is 1 for a read.
- R5: In 10-bit write mode two bytes are sent: the header {11110, addr[9:8], 0}, then addr[7:0].
- R6: A 10-bit read with the header-only option at 0 sends the header with rw=0, then addr[7:0], then a repeated START, then the header with rw=1. With the option at 1 it sends only the header with rw=1.
- R7: The acknowledge bit is sampled in the ninth SCL high phase of each byte. After the final byte, or after any NACK, `done` pulses for one cycle and `start_pending` is 0 in that same cycle. A NACK also sets `nack`.
- R8: After a NACK the block drives a STOP and then releases both lines, after which `bus_busy` reads 0.
- R9: If SDA reads low at the end of an SCL high phase in which the block released SDA, it does four things in the same cycle. It sets `arb_lost` and `target_mode`, clears `start_pending`, and releases SCL and SDA.
- R10: After the last address byte is acknowledged, the block keeps SCL pulled low (`scl_oe`=1) and `bus_busy` stays 1.
- R11: `bus_busy` is set one cycle after a START is seen on the lines and cleared one cycle after a STOP is seen, whichever node drives them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Latch the transfer description |
| cfg_ten_bit | input | 1 | 1 selects 10-bit addressing |
| cfg_addr | input | 10 | Target address |
| cfg_read | input | 1 | Direction, 1 = read |
| cfg_hdr_only | input | 1 | 10-bit read: send the header byte only |
| cfg_len | input | LEN_W | Requested transfer length |
| start_set | input | 1 | Raise the start request |
| tim_low | input | TIM_W | SCL low phase, bus-free and repeated-START setup count |
| tim_high | input | TIM_W | SCL high phase, START hold and STOP setup count |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| start_pending | output | 1 | Start request outstanding |
| xfer_count | output | 8 | Latched byte count |
| bus_busy | output | 1 | Bus owned by some node |
| done | output | 1 | One-cycle pulse when the address phase ends |
| nack | output | 1 | Last address phase was not acknowledged |
| arb_lost | output | 1 | Arbitration was lost |
| target_mode | output | 1 | Block has fallen back to target mode |

## Verification
Arbitration loss and the wait on a busy bus are the states hardest to reach from the ports. Each one needs a second node on the wires at exactly the right moment. The bench models the wired-AND bus with extra pull-downs it controls. In one test it pulls SDA low during the first address bit, which the block leaves released. In another it puts its own START on the bus before the request and a STOP later. It then counts the edges from that STOP to the block's START and writes a new configuration while the block is still held off.

// File: rtl/i2c_ss_pkg.sv
package i2c_ss_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_FREE, S_START, S_LOW, S_HIGH,
    S_RS_LOW, S_RS_HIGH, S_HOLD, S_STOP_LOW, S_STOP_HIGH
  } seq_state_e;

  localparam logic [4:0] HDR_TAG = 5'b11110;

  // Byte sent in a given stage of the address phase
  function automatic logic [7:0] addr_byte(input logic [1:0] stage,
                                           input logic ten,
                                           input logic [9:0] a,
                                           input logic rd,
                                           input logic hdr_only);
    if (!ten) return {a[6:0], rd};
    case (stage)
      2'd0:    return {HDR_TAG, a[9:8], rd & hdr_only};
      2'd1:    return a[7:0];
      default: return {HDR_TAG, a[9:8], 1'b1};
    endcase
  endfunction

  // Index of the final stage for the chosen addressing variant
  function automatic logic [1:0] last_stage(input logic ten,
                                            input logic rd,
                                            input logic hdr_only);
    if (!ten) return 2'd0;
    if (!rd) return 2'd1;
    if (hdr_only) return 2'd0;
    return 2'd2;
  endfunction

endpackage

// File: rtl/i2c_ss_busmon.sv
module i2c_ss_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic busy
);
  logic scl_q, sda_q;
  logic seen_start, seen_stop;

  assign seen_start = scl_i && scl_q && sda_q && !sda_i;
  assign seen_stop  = scl_i && scl_q && !sda_q && sda_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (seen_start)     busy <= 1'b1;
      else if (seen_stop) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_ss_cfg.sv
module i2c_ss_cfg #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             ten_in,
  input  logic [9:0]       addr_in,
  input  logic             rd_in,
  input  logic             hdr_in,
  input  logic [LEN_W-1:0] len_in,
  output logic             ten,
  output logic [9:0]       addr,
  output logic             rd,
  output logic             hdr,
  output logic [7:0]       count
);
  localparam logic [LEN_W-1:0] SAT = LEN_W'(255);
  logic [7:0] clamped;

  assign clamped = (len_in >= SAT) ? 8'hFF : len_in[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ten   <= 1'b0;
      addr  <= '0;
      rd    <= 1'b0;
      hdr   <= 1'b0;
      count <= '0;
    end else if (wr_en) begin
      ten   <= ten_in;
      addr  <= addr_in;
      rd    <= rd_in;
      hdr   <= hdr_in;
      count <= clamped;
    end
  end
endmodule

// File: rtl/i2c_start_seq.sv
module i2c_start_seq
  import i2c_ss_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int TIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_ten_bit,
  input  logic [9:0]       cfg_addr,
  input  logic             cfg_read,
  input  logic             cfg_hdr_only,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             start_set,
  input  logic [TIM_W-1:0] tim_low,
  input  logic [TIM_W-1:0] tim_high,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             start_pending,
  output logic [7:0]       xfer_count,
  output logic             bus_busy,
  output logic             done,
  output logic             nack,
  output logic             arb_lost,
  output logic             target_mode
);
  localparam logic [3:0] ACK_IDX = 4'd8;

  seq_state_e       state;
  logic [TIM_W-1:0] cnt;
  logic [7:0]       shreg;
  logic [3:0]       bitidx;
  logic [1:0]       stage;
  logic             c_ten, c_rd, c_hdr;
  logic [9:0]       c_addr;
  logic [1:0]       fin_stage;

  i2c_ss_cfg #(.LEN_W(LEN_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr && !start_pending),
    .ten_in(cfg_ten_bit), .addr_in(cfg_addr), .rd_in(cfg_read),
    .hdr_in(cfg_hdr_only), .len_in(cfg_len),
    .ten(c_ten), .addr(c_addr), .rd(c_rd), .hdr(c_hdr), .count(xfer_count)
  );

  i2c_ss_busmon u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .busy(bus_busy)
  );

  assign fin_stage = last_stage(c_ten, c_rd, c_hdr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      cnt           <= '0;
      shreg         <= '0;
      bitidx        <= '0;
      stage         <= '0;
      scl_oe        <= 1'b0;
      sda_oe        <= 1'b0;
      start_pending <= 1'b0;
      done          <= 1'b0;
      nack          <= 1'b0;
      arb_lost      <= 1'b0;
      target_mode   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start_set) begin
        start_pending <= 1'b1;
        nack          <= 1'b0;
        arb_lost      <= 1'b0;
        target_mode   <= 1'b0;
      end
      case (state)
        S_IDLE: begin
          scl_oe <= 1'b0;
          sda_oe <= 1'b0;
          if (start_pending && !bus_busy) begin
            state <= S_FREE;
            cnt   <= '0;
            stage <= '0;
          end
        end
        S_FREE: begin
          if (bus_busy) state <= S_IDLE;
          else if (cnt == tim_low) begin
            sda_oe <= 1'b1;
            cnt    <= '0;
            state  <= S_START;
          end else cnt <= cnt + 1'b1;
        end
        S_START: begin
          if (cnt == tim_high) begin
            scl_oe <= 1'b1;
            shreg  <= addr_byte(stage, c_ten, c_addr, c_rd, c_hdr);
            bitidx <= '0;
            cnt    <= '0;
            state  <= S_LOW;
          end else cnt <= cnt + 1'b1;
        end
        S_LOW: begin
          if (cnt == '0) sda_oe <= (bitidx == ACK_IDX) ? 1'b0 : ~shreg[7];
          if (cnt == tim_low) begin
            scl_oe <= 1'b0;
            cnt    <= '0;
            state  <= S_HIGH;
          end else cnt <= cnt + 1'b1;
        end
        S_HIGH: begin
          if (scl_i) begin
            if (cnt != tim_high) cnt <= cnt + 1'b1;
            else begin
              cnt    <= '0;
              scl_oe <= 1'b1;
              if (bitidx != ACK_IDX) begin
                if (shreg[7] && !sda_i) begin
                  scl_oe        <= 1'b0;
                  sda_oe        <= 1'b0;
                  arb_lost      <= 1'b1;
                  target_mode   <= 1'b1;
                  start_pending <= 1'b0;
                  state         <= S_IDLE;
                end else begin
                  shreg  <= {shreg[6:0], 1'b0};
                  bitidx <= bitidx + 1'b1;
                  state  <= S_LOW;
                end
              end else if (sda_i) begin
                nack          <= 1'b1;
                done          <= 1'b1;
                start_pending <= 1'b0;
                state         <= S_STOP_LOW;
              end else if (stage == fin_stage) begin
                done          <= 1'b1;
                start_pending <= 1'b0;
                state         <= S_HOLD;
              end else begin
                stage <= stage + 2'd1;
                if (stage == 2'd1) state <= S_RS_LOW;
                else begin
                  shreg  <= addr_byte(stage + 2'd1, c_ten, c_addr, c_rd, c_hdr);
                  bitidx <= '0;
                  state  <= S_LOW;
                end
              end
            end
          end
        end
        S_RS_LOW: begin
          if (cnt == '0) sda_oe <= 1'b0;
          if (cnt == tim_low) begin
            scl_oe <= 1'b0;
            cnt    <= '0;
            state  <= S_RS_HIGH;
          end else cnt <= cnt + 1'b1;
        end
        S_RS_HIGH: begin
          if (scl_i) begin
            if (cnt == tim_low) begin
              sda_oe <= 1'b1;
              cnt    <= '0;
              state  <= S_START;
            end else cnt <= cnt + 1'b1;
          end
        end
        S_HOLD: begin
          scl_oe <= 1'b1;
          if (start_pending) begin
            stage <= '0;
            cnt   <= '0;
            state <= S_RS_LOW;
          end
        end
        S_STOP_LOW: begin
          if (cnt == '0) sda_oe <= 1'b1;
          if (cnt == tim_low) begin
            scl_oe <= 1'b0;
            cnt    <= '0;
            state  <= S_STOP_HIGH;
          end else cnt <= cnt + 1'b1;
        end
        S_STOP_HIGH: begin
          if (scl_i) begin
            if (cnt == tim_high) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= S_IDLE;
            end else cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_ss_checker.sv
module i2c_ss_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_i,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       start_pending,
  input logic [7:0] xfer_count,
  input logic       bus_busy,
  input logic       done,
  input logic       arb_lost,
  input logic       target_mode
);
  p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_pending |=> $stable(xfer_count));

  p_done_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !start_pending);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_arb_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> (!scl_oe && !sda_oe && target_mode && !start_pending));

  p_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sda_i) && !sda_i && scl_i && $past(scl_i)) |=> bus_busy);

  p_busy_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sda_i) && sda_i && scl_i && $past(scl_i)) |=> !bus_busy);
endmodule

bind i2c_start_seq i2c_ss_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .start_pending(start_pending),
  .xfer_count(xfer_count), .bus_busy(bus_busy), .done(done),
  .arb_lost(arb_lost), .target_mode(target_mode)
);

// File: tb/i2c_start_seq_bench.sv
module i2c_start_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 16;
  localparam int TIM_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_ten_bit = 1'b0, cfg_read = 1'b0, cfg_hdr_only = 1'b0;
  logic [9:0] cfg_addr = '0;
  logic [LEN_W-1:0] cfg_len = '0;
  logic start_set = 1'b0;
  logic [TIM_W-1:0] tim_low = 8'd4, tim_high = 8'd3;
  logic scl_oe, sda_oe, start_pending, bus_busy, done, nack, arb_lost, target_mode;
  logic [7:0] xfer_count;

  logic ext_scl = 1'b0, ext_sda = 1'b0, ack_en = 1'b1, arb_en = 1'b0;
  logic tgt_pull = 1'b0, arb_pull = 1'b0;
  logic scl_line, sda_line;
  assign scl_line = ~scl_oe & ~ext_scl;
  assign sda_line = ~sda_oe & ~tgt_pull & ~arb_pull & ~ext_sda;

  int checks = 0, errors = 0;
  int starts = 0, stops = 0, rx_n = 0, bitcnt = 0;
  logic [7:0] shift = '0;
  logic [7:0] rx [16];
  logic pscl = 1'b1, psda = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_start_seq #(.LEN_W(LEN_W), .TIM_W(TIM_W)) u_i2c_start_seq (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_ten_bit(cfg_ten_bit),
    .cfg_addr(cfg_addr), .cfg_read(cfg_read), .cfg_hdr_only(cfg_hdr_only),
    .cfg_len(cfg_len), .start_set(start_set), .tim_low(tim_low), .tim_high(tim_high),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .start_pending(start_pending), .xfer_count(xfer_count), .bus_busy(bus_busy),
    .done(done), .nack(nack), .arb_lost(arb_lost), .target_mode(target_mode)
  );

  // Target and competing-controller model on the wired-AND bus
  always @(posedge clk) begin
    if (scl_line && pscl && psda && !sda_line) begin
      starts <= starts + 1;
      bitcnt <= 0;
    end else if (scl_line && pscl && !psda && sda_line) begin
      stops <= stops + 1;
    end else if (scl_line && !pscl) begin
      if (bitcnt < 8) shift <= {shift[6:0], sda_line};
      bitcnt <= bitcnt + 1;
    end else if (!scl_line && pscl) begin
      if (bitcnt == 8) tgt_pull <= ack_en;
      if (bitcnt == 9) begin
        tgt_pull <= 1'b0;
        rx[rx_n[3:0]] <= shift;
        rx_n <= rx_n + 1;
        bitcnt <= 0;
      end
      if (arb_en && bitcnt == 0) arb_pull <= 1'b1;
    end
    if (arb_lost) arb_pull <= 1'b0;
    pscl <= scl_line;
    psda <= sda_line;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ack_en = 1'b1; arb_en = 1'b0; ext_scl = 1'b0; ext_sda = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic write_cfg(input logic ten, input logic [9:0] a, input logic rd,
                           input logic hdr, input logic [LEN_W-1:0] len);
    @(negedge clk);
    cfg_ten_bit = ten; cfg_addr = a; cfg_read = rd; cfg_hdr_only = hdr; cfg_len = len;
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic request();
    @(negedge clk);
    start_set = 1'b1;
    @(negedge clk);
    start_set = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    do @(negedge clk); while (!done);
    check({tag, " R7 pending cleared with done"}, start_pending, 0);
  endtask

  task automatic t_reset_state();
    do_reset();
    check("reset scl_oe", scl_oe, 0);
    check("reset sda_oe", sda_oe, 0);
    check("reset start_pending", start_pending, 0);
    check("reset bus_busy", bus_busy, 0);
    check("reset done", done, 0);
  endtask

  task automatic t_count_clamp();
    do_reset();
    write_cfg(0, 10'h10, 0, 0, 16'd300); check("R1 len 300", xfer_count, 8'hFF);
    write_cfg(0, 10'h10, 0, 0, 16'd255); check("R1 len 255", xfer_count, 8'hFF);
    write_cfg(0, 10'h10, 0, 0, 16'd254); check("R1 len 254", xfer_count, 8'hFE);
    write_cfg(0, 10'h10, 0, 0, 16'd17);  check("R1 len 17", xfer_count, 8'd17);
    write_cfg(0, 10'h10, 0, 0, 16'd0);   check("R1 len 0", xfer_count, 8'd0);
  endtask

  task automatic t_seven_bit_read();
    int n0;
    do_reset();
    n0 = rx_n;
    write_cfg(0, 10'h03B, 1, 0, 16'd5);
    request();
    check("R7 pending after request", start_pending, 1);
    wait_done("7bit");
    check("R7 ack gives no nack", nack, 0);
    repeat (20) @(negedge clk);
    check("R4 byte count", rx_n - n0, 1);
    check("R4 7-bit read byte", rx[n0[3:0]], 8'h77);
    check("R10 SCL held low", scl_oe, 1);
    check("R10 bus stays busy", bus_busy, 1);
  endtask

  task automatic t_ten_write();
    int n0, s0;
    do_reset();
    n0 = rx_n; s0 = starts;
    write_cfg(1, 10'h13C, 0, 0, 16'd2);
    request();
    wait_done("10bit write");
    repeat (20) @(negedge clk);
    check("R5 byte count", rx_n - n0, 2);
    check("R5 header", rx[n0[3:0]], 8'hF2);
    check("R5 low address", rx[4'(n0 + 1)], 8'h3C);
    check("R5 single START", starts - s0, 1);
  endtask

  task automatic t_ten_read(input logic hdr);
    int n0, s0;
    do_reset();
    n0 = rx_n; s0 = starts;
    write_cfg(1, 10'h2A5, 1, hdr, 16'd4);
    request();
    wait_done("10bit read");
    repeat (20) @(negedge clk);
    if (!hdr) begin
      check("R6 full byte count", rx_n - n0, 3);
      check("R6 write header", rx[n0[3:0]], 8'hF4);
      check("R6 low address", rx[4'(n0 + 1)], 8'hA5);
      check("R6 read header", rx[4'(n0 + 2)], 8'hF5);
      check("R6 repeated START seen", starts - s0, 2);
    end else begin
      check("R6 header-only byte count", rx_n - n0, 1);
      check("R6 header-only byte", rx[n0[3:0]], 8'hF5);
    end
  endtask

  task automatic t_nack_stop();
    int n0, p0;
    do_reset();
    ack_en = 1'b0;
    n0 = rx_n; p0 = stops;
    write_cfg(0, 10'h050, 0, 0, 16'd1);
    request();
    wait_done("nack");
    check("R7 nack flag", nack, 1);
    repeat (40) @(negedge clk);
    check("R8 byte sent", rx[n0[3:0]], 8'hA0);
    check("R8 STOP driven", stops - p0, 1);
    check("R8 bus idle", bus_busy, 0);
    check("R8 scl released", scl_oe, 0);
    check("R8 sda released", sda_oe, 0);
  endtask

  task automatic t_wait_busy();
    int n0;
    do_reset();
    n0 = rx_n;
    @(negedge clk); ext_sda = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 busy after foreign START", bus_busy, 1);
    write_cfg(0, 10'h021, 0, 0, 16'd3);
    request();
    repeat (40) @(negedge clk);
    check("R3 no START while busy", sda_oe, 0);
    check("R3 SCL untouched while busy", scl_oe, 0);
    check("R3 request still pending", start_pending, 1);
    write_cfg(0, 10'h02E, 1, 0, 16'd200);
    check("R2 count frozen", xfer_count, 8'd3);
    ext_sda = 1'b0;
    repeat (6) @(negedge clk);
    check("R3 bus-free delay not yet elapsed", sda_oe, 0);
    @(negedge clk);
    check("R3 START after bus-free delay", sda_oe, 1);
    wait_done("busy wait");
    repeat (20) @(negedge clk);
    check("R2 original address sent", rx[n0[3:0]], 8'h42);
    check("R2 count kept", xfer_count, 8'd3);
  endtask

  task automatic t_arb();
    do_reset();
    write_cfg(0, 10'h055, 0, 0, 16'd1);
    arb_en = 1'b1;
    request();
    do @(negedge clk); while (!arb_lost);
    check("R9 target mode", target_mode, 1);
    check("R9 pending cleared", start_pending, 0);
    check("R9 scl released", scl_oe, 0);
    check("R9 sda released", sda_oe, 0);
    check("R9 no done pulse", done, 0);
    arb_en = 1'b0;
    repeat (10) @(negedge clk);
    check("R11 busy cleared by foreign STOP", bus_busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset_state();
    t_count_clamp();
    t_seven_bit_read();
    t_ten_write();
    t_ten_read(1'b0);
    t_ten_read(1'b1);
    t_nack_stop();
    t_wait_busy();
    t_arb();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule